// File: doc/BRIEF.md
# Serially Programmed Twelve-Channel Setting Bank

This block holds twelve independent 8-bit setting values, each meant to drive one analog trim converter. A host writes them over a three-wire serial link made of an active-low select (`cs_n`), a serial clock (`sclk`) and a data line (`sdi`). Each transfer is a 12-bit frame. The frame carries a 4-bit channel number followed by an 8-bit value. The value is committed only when the select line is released.

All three serial lines are brought into the system clock domain through synchronizers. Clock and select edges are detected there. A commit is taken only when exactly twelve or more bits arrived in the select window. With more than twelve bits, the most recent twelve count.

An asynchronous active-low preset forces every channel to midscale, 0x80, at any time. An active-low shutdown request is synchronized and passed out as a power-down flag. The stored settings are left untouched while it is asserted.

Top module: `serial_bank`

## Requirements
- R1: While `rst` is high, and after it falls, every channel reads 0x80 and `pwr_down` reads 0.
- R2: Bits are taken MSB first on each rising `sclk` while `cs_n` is low. The first four bits form the channel number and the last eight bits form the value. Channel number k (0 to 11) selects `ch_vals[8k+7:8k]`.
- R3: Shifting a complete frame changes no channel while `cs_n` stays low. Only the release of `cs_n` commits the frame.
- R4: A frame whose channel number is 12 to 15 leaves every channel unchanged.
- R5: When more than twelve `sclk` rises occur in one select window, the last twelve bits received form the frame.
- R6: When fewer than twelve `sclk` rises occur in one select window, the frame is dropped and no channel changes.
- R7: Driving `preset_n` low sets all twelve channels to 0x80 at once, without waiting for a `clk` edge.
- R8: `pwr_down` is the inverse of `shdn_n` after two `clk` edges. Asserting or releasing shutdown does not alter any channel value.
- R9: A committed write changes only the addressed channel. Every other channel keeps its value until it is itself rewritten.
- R10: After `cs_n` is first sampled high by a rising `clk` edge, the addressed channel shows the new value after the fourth rising edge, and not after the third.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock; data sampled on its rise |
| sdi | input | 1 | Serial data, MSB first |
| preset_n | input | 1 | Asynchronous active-low midscale preset |
| shdn_n | input | 1 | Active-low shutdown request |
| ch_vals | output | 96 | Twelve 8-bit channel values; channel k at bits 8k+7:8k |
| pwr_down | output | 1 | Synchronized shutdown flag, active high |

## Verification
A fault in the shift path, such as a wrong bit order or a wrong bit count, shows up as the wrong value or the wrong channel. It appears four clock cycles after the select is released, so every frame is checked against a model snapshot of all twelve channels, not only the target channel. A fault in the address decode or in commit gating shows up as a change to a bystander channel or as a premature change while select is still low. The bench therefore compares the whole output vector mid-frame and after frames that must be discarded. The commit latency is checked at the exact edge on both sides of the update.

// File: rtl/serial_bank_pkg.sv
package serial_bank_pkg;

    localparam int NUM_CH      = 12;
    localparam int ADDR_W      = 4;
    localparam int DATA_W      = 8;
    localparam int FRAME_W     = ADDR_W + DATA_W;
    localparam int CNT_W       = $clog2(FRAME_W + 1);
    localparam int SYNC_STAGES = 2;

    localparam logic [DATA_W-1:0] MID_VAL = DATA_W'(1) << (DATA_W - 1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;

    typedef logic [NUM_CH-1:0][DATA_W-1:0] bank_t;

    function automatic logic addr_ok(input logic [ADDR_W-1:0] a);
        return a < ADDR_W'(NUM_CH);
    endfunction

endpackage

// File: rtl/sb_sync.sv
module sb_sync #(
    parameter int         W       = 1,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sb_shifter.sv
module sb_shifter
    import serial_bank_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   csn_s,
    input  logic   sclk_s,
    input  logic   sdi_s,
    output logic   commit,
    output frame_t frame
);
    logic               csn_d;
    logic               sclk_d;
    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   cnt;
    logic               sclk_rise;
    logic               cs_rise;
    logic               full;

    assign sclk_rise = sclk_s & ~sclk_d;
    assign cs_rise   = csn_s & ~csn_d;
    assign full      = (cnt == CNT_W'(FRAME_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            csn_d  <= 1'b1;
            sclk_d <= 1'b0;
            shreg  <= '0;
            cnt    <= '0;
            commit <= 1'b0;
            frame  <= '0;
        end else begin
            csn_d  <= csn_s;
            sclk_d <= sclk_s;
            commit <= cs_rise & full;
            if (cs_rise) frame <= frame_t'(shreg);
            if (csn_s) begin
                cnt <= '0;
            end else if (sclk_rise) begin
                shreg <= {shreg[FRAME_W-2:0], sdi_s};
                if (!full) cnt <= cnt + CNT_W'(1);
            end
        end
    end

    // R5: bit counter saturates at the frame length
    a_r5_cnt_saturates: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(FRAME_W));

    // R3: a commit is only ever issued once select is seen released
    a_r3_commit_cs_high: assert property (@(posedge clk) disable iff (rst)
        commit |-> csn_d);

    // R6: while select is idle no bits are counted
    a_r6_idle_no_count: assert property (@(posedge clk) disable iff (rst)
        (csn_s && csn_d) |=> (cnt == '0));
endmodule

// File: rtl/sb_bank.sv
module sb_bank
    import serial_bank_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   preset_n,
    input  logic   we,
    input  frame_t frame,
    output bank_t  regs
);
    logic wr_ok;
    assign wr_ok = we & addr_ok(frame.addr);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic hit;
        assign hit = wr_ok & (frame.addr == ADDR_W'(i));

        always_ff @(posedge clk or negedge preset_n) begin
            if (!preset_n)   regs[i] <= MID_VAL;
            else if (rst)    regs[i] <= MID_VAL;
            else if (hit)    regs[i] <= frame.data;
        end

        // R2: a write to this channel lands its data on the next edge
        a_r2_write_lands: assert property (@(posedge clk) disable iff (rst || !preset_n)
            (we && frame.addr == ADDR_W'(i)) |=> (regs[i] == $past(frame.data)));
    end

    // R4: out-of-range channel numbers change nothing
    a_r4_bad_addr_ignored: assert property (@(posedge clk) disable iff (rst || !preset_n)
        (we && !addr_ok(frame.addr)) |=> $stable(regs));

    // R9: without a write strobe the bank holds
    a_r9_hold_without_write: assert property (@(posedge clk) disable iff (rst || !preset_n)
        !we |=> $stable(regs));
endmodule

// File: rtl/serial_bank.sv
module serial_bank
    import serial_bank_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cs_n,
    input  logic                     sclk,
    input  logic                     sdi,
    input  logic                     preset_n,
    input  logic                     shdn_n,
    output logic [NUM_CH*DATA_W-1:0] ch_vals,
    output logic                     pwr_down
);
    logic   csn_s, sclk_s, sdi_s, shdn_s;
    logic   commit;
    frame_t frame;
    bank_t  regs;

    sb_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({cs_n, sclk, sdi, shdn_n}),
        .q   ({csn_s, sclk_s, sdi_s, shdn_s})
    );

    sb_shifter u_shift (
        .clk    (clk),
        .rst    (rst),
        .csn_s  (csn_s),
        .sclk_s (sclk_s),
        .sdi_s  (sdi_s),
        .commit (commit),
        .frame  (frame)
    );

    sb_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .preset_n (preset_n),
        .we       (commit),
        .frame    (frame),
        .regs     (regs)
    );

    assign ch_vals  = regs;
    assign pwr_down = ~shdn_s;

    // R8: a rise of the flag follows a low request two edges earlier
    a_r8_pwr_follows: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_down) |-> !$past(shdn_n, 2));
endmodule

// File: tb/test_serial_bank.sv
module test_serial_bank;
    localparam int NCH = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic preset_n = 1'b1, shdn_n = 1'b1;
    logic [NCH*8-1:0] ch_vals;
    logic pwr_down;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0]       model [NCH];
    logic [NCH*8-1:0] exp_q [$];
    string            tag_q [$];

    serial_bank i_serial_bank (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .preset_n(preset_n), .shdn_n(shdn_n), .ch_vals(ch_vals), .pwr_down(pwr_down)
    );

    always #10 clk = ~clk;

    function automatic logic [NCH*8-1:0] snap();
        logic [NCH*8-1:0] v;
        for (int k = 0; k < NCH; k++) v[k*8 +: 8] = model[k];
        return v;
    endfunction

    task automatic check_vec(input string tag, input logic [NCH*8-1:0] exp);
        checks++;
        if (ch_vals !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, ch_vals, exp);
        end
    endtask

    task automatic check_bit(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %b exp %b", tag, got, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // shifts n bits MSB first; leaves cs_n low
    task automatic shift_bits(input logic [31:0] bits, input int n);
        cs_n = 1'b0;
        wait_clk(4);
        for (int b = n - 1; b >= 0; b--) begin
            sdi = bits[b];
            wait_clk(4);
            sclk = 1'b1;
            wait_clk(4);
            sclk = 1'b0;
        end
        wait_clk(4);
    endtask

    // driver: full transfer, model update, expected snapshot pushed
    task automatic send(input logic [31:0] bits, input int n, input string tag);
        logic [11:0] f;
        shift_bits(bits, n);
        cs_n = 1'b1;
        wait_clk(8);
        f = bits[11:0];
        if (n >= 12 && f[11:8] < 4'd12) model[f[11:8]] = f[7:0];
        exp_q.push_back(snap());
        tag_q.push_back(tag);
        wait_clk(2);
    endtask

    // monitor: pops expected snapshots and compares
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [NCH*8-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            #1 check_vec(t, e);
        end
    end

    initial begin
        for (int k = 0; k < NCH; k++) model[k] = 8'h80;
        wait_clk(3);
        check_vec("R1 reset during rst", snap());
        rst = 1'b0;
        wait_clk(4);
        check_vec("R1 reset after rst", snap());
        check_bit("R1 pwr_down after reset", pwr_down, 1'b0);

        send(32'h03C, 12, "R2 ch0 write");
        send(32'hB5A, 12, "R2 ch11 write");
        send(32'h4A7, 12, "R9 ch4 only");
        send(32'h711, 12, "R2 ch7 write");

        // R3: complete frame but select held low
        shift_bits(32'h2EE, 12);
        wait_clk(10);
        check_vec("R3 no change while cs low", snap());
        cs_n = 1'b1;
        wait_clk(8);
        model[2] = 8'hEE;
        exp_q.push_back(snap()); tag_q.push_back("R3 commit on release");
        wait_clk(2);

        send(32'hC55, 12, "R4 addr 12 ignored");
        send(32'hFAA, 12, "R4 addr 15 ignored");
        send(32'hF3_963, 20, "R5 long frame last 12");
        send(32'h0AB, 8, "R6 short frame dropped");
        send(32'h5FF, 11, "R6 eleven bits dropped");

        // R10: exact commit edge
        shift_bits(32'h9C3, 12);
        cs_n = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(posedge clk);
        #1 check_vec("R10 old after third edge", snap());
        model[9] = 8'hC3;
        @(posedge clk);
        #1 check_vec("R10 new after fourth edge", snap());
        wait_clk(4);

        // R8: shutdown keeps settings
        shdn_n = 1'b0;
        @(posedge clk);
        #1 check_bit("R8 flag not yet after one edge", pwr_down, 1'b0);
        @(posedge clk);
        #1 check_bit("R8 flag after two edges", pwr_down, 1'b1);
        wait_clk(5);
        check_vec("R8 values kept in shutdown", snap());
        shdn_n = 1'b1;
        wait_clk(3);
        check_bit("R8 flag released", pwr_down, 1'b0);
        check_vec("R8 values kept after resume", snap());
        send(32'h612, 12, "R8 write after resume");

        // R7: asynchronous preset, checked before any clock edge
        @(negedge clk);
        #2 preset_n = 1'b0;
        #1;
        for (int k = 0; k < NCH; k++) model[k] = 8'h80;
        check_vec("R7 async preset midscale", snap());
        wait_clk(2);
        preset_n = 1'b1;
        wait_clk(2);
        send(32'h133, 12, "R7 write after preset");

        wait_clk(5);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #3000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired got timeout exp completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule